// File: doc/BRIEF.md
# Posted Memory Write Target Acceptor

This block is the target half of one bridge port. It watches a PCI bus for memory write bursts, claims the ones it may post, and moves the address and every accepted DWORD into a write queue. It does this without first winning the bus on the far side. An external decoder supplies a single `hit` bit in the address phase, which stands in for the address window match. The queue is an external FIFO. The block sees only its count of free entries, and it writes into the FIFO through a single-cycle push interface.

A claimed burst runs at full rate. After medium-speed decode and one setup clock, one DWORD is taken on every clock in which the initiator is ready. The burst stops in one of three ways. The initiator may end it. The next DWORD may fall in a new aligned block (a cache line for the invalidate form of the write, a 4 KB page for the other forms). Or the queue may be down to its last free slot. In the last two cases the block issues a disconnect-with-data on the final phase it accepts. In the queue, each burst is one address entry followed by its data entries, and the final data entry carries an end flag.

Top module: `wrpost_target`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, `devsel_n`, `trdy_n` and `stop_n` are high and `q_push` is low.
- R2: Only three command codes are posted: 4'b0111 (memory write), 4'b1111 (memory write and invalidate) and 4'b1001 (memory write block). Any other command, such as 4'b0011 or 4'b1011, never drives `devsel_n` low and pushes nothing.
- R3: A posted command is claimed only if `hit` was high in the address phase and `fifo_free` >= 2 in the clock after the address phase. Otherwise `devsel_n` stays high, so the initiator sees a master abort, and nothing is pushed.
- R4: The address phase is the first clock with `frame_n` low after a clock with `frame_n` high, while `irdy_n` is high. A claimed burst drives `devsel_n` low in the second clock after the address phase and `trdy_n` low in the clock after that.
- R5: In the first clock with `devsel_n` low, one address entry is pushed: `q_is_addr`=1, `q_word` = the address, `q_tag` = the command code, `q_last`=0.
- R6: While `trdy_n` is low, every clock with `irdy_n` low pushes one data entry: `q_is_addr`=0, `q_word`=`ad`, `q_tag`=~`cbe_n`. A clock with `irdy_n` high pushes nothing, and the burst continues.
- R7: A data phase completed with `frame_n` high is the last one. Its entry has `q_last`=1, and in the next clock `devsel_n`, `trdy_n` and `stop_n` are all high.
- R8: If the DWORD of the current phase is the last one before an aligned block boundary, `stop_n` is low on that phase and its entry has `q_last`=1. The block is CL_DW DWORDs (default 8) for 4'b1111 and PAGE_DW DWORDs (default 1024, 4 KB) for 4'b0111 and 4'b1001.
- R9: `stop_n` is low on any data phase that takes the last free queue slot. The block never pushes when `fifo_free` is 0.
- R10: After a disconnect phase completes with `frame_n` still low, `trdy_n` goes high while `stop_n` and `devsel_n` stay low. All three go high in the clock after the one in which `frame_n` is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_n | input | 1 | Initiator cycle frame, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| ad | input | 32 | Address in the address phase, data in data phases |
| cbe_n | input | 4 | Command in the address phase, active-low byte enables in data phases |
| hit | input | 1 | Address window match, valid in the address phase |
| fifo_free | input | FREE_W | Free entries in the write queue |
| devsel_n | output | 1 | Target claim, active low |
| trdy_n | output | 1 | Target ready, active low |
| stop_n | output | 1 | Target stop (disconnect), active low |
| q_push | output | 1 | Queue write strobe |
| q_is_addr | output | 1 | Entry is an address/command entry |
| q_last | output | 1 | Entry is the last data of its burst |
| q_tag | output | 4 | Command code (address entry) or active-high byte enables (data entry) |
| q_word | output | 32 | Address or data word |

## Verification
The address counter and the control state drive the bus handshake directly. An off-by-one in the counter or a wrong block mask shows up as `stop_n` arriving one phase early or late, and the data entry count changes in that same burst. A wrong claim decision shows within three clocks of the address phase: either `devsel_n` appears on a burst that should end in master abort, or an address entry is pushed with no claim. A slip in the free-space arithmetic shows as a push at zero free space, or as one DWORD too many before the disconnect.

// File: rtl/wrpost_pkg.sv
// Package: shared state encoding and command codes for the posted write target.
// Assumes 4-bit bus commands; only the three posted write codes are named here.
package wrpost_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DECODE,
        ST_CLAIM,
        ST_DATA,
        ST_DISC,
        ST_IGNORE
    } wrpost_state_t;

    localparam logic [3:0] CMD_MEM_WR     = 4'b0111;
    localparam logic [3:0] CMD_MEM_WR_INV = 4'b1111;
    localparam logic [3:0] CMD_MEM_WR_BLK = 4'b1001;

endpackage

// File: rtl/wrpost_cmd_dec.sv
// Module: classifies the latched bus command.
// Outputs whether it may be posted, and the DWORD mask of the aligned block
// that bounds the burst. Assumes CL_DW and PAGE_DW are powers of two.
module wrpost_cmd_dec
    import wrpost_pkg::*;
#(
    parameter int CL_DW   = 8,
    parameter int PAGE_DW = 1024
) (
    input  logic [3:0]  cmd,
    output logic        posted,
    output logic [29:0] blk_mask
);
    localparam logic [29:0] CL_MASK   = 30'(CL_DW - 1);
    localparam logic [29:0] PAGE_MASK = 30'(PAGE_DW - 1);

    // Decide postability and pick the boundary block size for the command.
    always_comb begin
        posted   = (cmd == CMD_MEM_WR) || (cmd == CMD_MEM_WR_INV) || (cmd == CMD_MEM_WR_BLK);
        blk_mask = (cmd == CMD_MEM_WR_INV) ? CL_MASK : PAGE_MASK;
    end

endmodule

// File: rtl/wrpost_addr_ctr.sv
// Module: DWORD address counter for the current data phase.
// It loads in the address phase and steps by one DWORD (4 bytes) per accepted
// phase. It flags whether the current or the following DWORD is the last one
// of its aligned block.
module wrpost_addr_ctr (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  logic [29:0] load_dw,
    input  logic        step,
    input  logic [29:0] blk_mask,
    output logic [29:0] cur_dw,
    output logic        cur_last,
    output logic        nxt_last
);
    logic [29:0] nxt_dw;

    // Hold the DWORD address of the data phase in progress.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cur_dw <= '0;
        else if (load)
            cur_dw <= load_dw;
        else if (step)
            cur_dw <= nxt_dw;
    end

    // Boundary flags: low address bits all ones means last DWORD of the block.
    always_comb begin
        nxt_dw   = cur_dw + 30'd1;
        cur_last = (cur_dw & blk_mask) == blk_mask;
        nxt_last = (nxt_dw & blk_mask) == blk_mask;
    end

endmodule

// File: rtl/wrpost_ctrl.sv
// Module: target control state machine.
// It finds the address phase, makes the claim with medium decode timing,
// paces data with no wait states and chooses the disconnect phase.
// Assumes only this block pushes into the queue, so fifo_free can only
// rise between its own pushes.
module wrpost_ctrl
    import wrpost_pkg::*;
#(
    parameter int FREE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_n,
    input  logic              irdy_n,
    input  logic              hit_q,
    input  logic              posted,
    input  logic [FREE_W-1:0] fifo_free,
    input  logic              cur_last,
    input  logic              nxt_last,
    output logic              addr_phase,
    output logic              xfer,
    output logic              push_addr,
    output logic              devsel_n,
    output logic              trdy_n,
    output logic              stop_n
);
    localparam logic [FREE_W-1:0] ONE = FREE_W'(1);
    localparam logic [FREE_W-1:0] TWO = FREE_W'(2);

    wrpost_state_t state;
    logic          frame_q;

    // Combinational strobes derived from the state and the initiator pins.
    always_comb begin
        addr_phase = (state == ST_IDLE) && !frame_n && frame_q && irdy_n;
        xfer       = (state == ST_DATA) && !irdy_n;
        push_addr  = (state == ST_CLAIM);
    end

    // Advance the handshake state and register the target pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            frame_q  <= 1'b1;
            devsel_n <= 1'b1;
            trdy_n   <= 1'b1;
            stop_n   <= 1'b1;
        end else begin
            frame_q <= frame_n;
            case (state)
                ST_IDLE: begin
                    if (addr_phase)
                        state <= ST_DECODE;
                end
                ST_DECODE: begin
                    if (hit_q && posted && (fifo_free >= TWO)) begin
                        state    <= ST_CLAIM;
                        devsel_n <= 1'b0;
                    end else begin
                        state <= ST_IGNORE;
                    end
                end
                ST_CLAIM: begin
                    state  <= ST_DATA;
                    trdy_n <= 1'b0;
                    stop_n <= !(cur_last || (fifo_free <= TWO));
                end
                ST_DATA: begin
                    if (xfer) begin
                        if (frame_n) begin
                            state    <= ST_IDLE;
                            devsel_n <= 1'b1;
                            trdy_n   <= 1'b1;
                            stop_n   <= 1'b1;
                        end else if (!stop_n) begin
                            state  <= ST_DISC;
                            trdy_n <= 1'b1;
                        end else begin
                            stop_n <= !(nxt_last || (fifo_free <= TWO));
                        end
                    end else begin
                        stop_n <= !(cur_last || (fifo_free <= ONE));
                    end
                end
                ST_DISC: begin
                    if (frame_n) begin
                        state    <= ST_IDLE;
                        devsel_n <= 1'b1;
                        stop_n   <= 1'b1;
                    end
                end
                ST_IGNORE: begin
                    if (frame_n && irdy_n)
                        state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/wrpost_target.sv
// Module: top of the posted memory write target acceptor.
// It latches the command, decode hit and address in the address phase, and
// builds the queue entries from the control strobes. Assumes the queue
// accepts an entry on every clock edge at which q_push is high.
module wrpost_target #(
    parameter int CL_DW   = 8,
    parameter int PAGE_DW = 1024,
    parameter int FREE_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_n,
    input  logic              irdy_n,
    input  logic [31:0]       ad,
    input  logic [3:0]        cbe_n,
    input  logic              hit,
    input  logic [FREE_W-1:0] fifo_free,
    output logic              devsel_n,
    output logic              trdy_n,
    output logic              stop_n,
    output logic              q_push,
    output logic              q_is_addr,
    output logic              q_last,
    output logic [3:0]        q_tag,
    output logic [31:0]       q_word
);
    logic [3:0]  cmd_q;
    logic        hit_q;
    logic [1:0]  addr_lo;
    logic        posted;
    logic [29:0] blk_mask;
    logic [29:0] cur_dw;
    logic        cur_last;
    logic        nxt_last;
    logic        addr_phase;
    logic        xfer;
    logic        push_addr;

    // Capture command, decode result and byte offset in the address phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q   <= '0;
            hit_q   <= 1'b0;
            addr_lo <= '0;
        end else if (addr_phase) begin
            cmd_q   <= cbe_n;
            hit_q   <= hit;
            addr_lo <= ad[1:0];
        end
    end

    wrpost_cmd_dec #(
        .CL_DW   (CL_DW),
        .PAGE_DW (PAGE_DW)
    ) u_dec (
        .cmd      (cmd_q),
        .posted   (posted),
        .blk_mask (blk_mask)
    );

    wrpost_addr_ctr u_actr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (addr_phase),
        .load_dw  (ad[31:2]),
        .step     (xfer),
        .blk_mask (blk_mask),
        .cur_dw   (cur_dw),
        .cur_last (cur_last),
        .nxt_last (nxt_last)
    );

    wrpost_ctrl #(
        .FREE_W (FREE_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_n    (frame_n),
        .irdy_n     (irdy_n),
        .hit_q      (hit_q),
        .posted     (posted),
        .fifo_free  (fifo_free),
        .cur_last   (cur_last),
        .nxt_last   (nxt_last),
        .addr_phase (addr_phase),
        .xfer       (xfer),
        .push_addr  (push_addr),
        .devsel_n   (devsel_n),
        .trdy_n     (trdy_n),
        .stop_n     (stop_n)
    );

    // Form the queue entry: address/command in the claim clock, data otherwise.
    always_comb begin
        q_push    = push_addr || xfer;
        q_is_addr = push_addr;
        q_last    = xfer && (frame_n || !stop_n);
        q_tag     = push_addr ? cmd_q : ~cbe_n;
        q_word    = push_addr ? {cur_dw, addr_lo} : ad;
    end

endmodule

// File: rtl/wrpost_target_chk.sv
// Module: protocol checker for wrpost_target, attached by bind.
// It relates the bus pins and the queue strobes over time.
module wrpost_target_chk #(
    parameter int FREE_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_n,
    input logic              irdy_n,
    input logic [FREE_W-1:0] fifo_free,
    input logic              devsel_n,
    input logic              trdy_n,
    input logic              stop_n,
    input logic              q_push,
    input logic              q_is_addr
);
    // R3: a claim is only made with room for address plus one DWORD.
    p_claim_space_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(devsel_n) |-> ($past(fifo_free) >= FREE_W'(2)));

    // R4: medium decode, two clocks after the clock that lowered frame_n.
    p_medium_decode_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(devsel_n) |-> (!$past(frame_n, 2) && $past(frame_n, 3)));

    // R4: target ready follows an already asserted claim.
    p_trdy_after_claim_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(trdy_n) |-> (!devsel_n && $past(!devsel_n)));

    // R5: the first claim clock pushes the address entry.
    p_addr_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(devsel_n) |-> (q_push && q_is_addr));

    // R6: every completed data phase pushes one data entry.
    p_full_rate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!trdy_n && !irdy_n) |-> (q_push && !q_is_addr));

    // R7: a final phase releases all target pins in the next clock.
    p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!trdy_n && !irdy_n && frame_n) |=> (devsel_n && trdy_n && stop_n));

    // R9: never push into a full queue.
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        q_push |-> (fifo_free != '0));

    // R10: a disconnect keeps stop and claim asserted while frame_n stays low.
    p_disc_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!stop_n && trdy_n && !frame_n) |=> (!stop_n && !devsel_n));

endmodule

bind wrpost_target wrpost_target_chk #(.FREE_W(FREE_W)) u_wrpost_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_n   (frame_n),
    .irdy_n    (irdy_n),
    .fifo_free (fifo_free),
    .devsel_n  (devsel_n),
    .trdy_n    (trdy_n),
    .stop_n    (stop_n),
    .q_push    (q_push),
    .q_is_addr (q_is_addr)
);

// File: tb/test_wrpost_target.sv
`timescale 1ns/1ps
module test_wrpost_target;
    localparam int FREE_W = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              frame_n = 1'b1;
    logic              irdy_n = 1'b1;
    logic [31:0]       ad = '0;
    logic [3:0]        cbe_n = 4'hF;
    logic              hit = 1'b0;
    logic [FREE_W-1:0] fifo_free;
    logic              devsel_n, trdy_n, stop_n;
    logic              q_push, q_is_addr, q_last;
    logic [3:0]        q_tag;
    logic [31:0]       q_word;

    int errors = 0;
    int checks = 0;
    int free_init = 20;
    int base = 0;
    int cnt_push = 0;
    bit finished = 0;

    logic [31:0] m_word [256];
    logic [3:0]  m_tag  [256];
    logic        m_addr [256];
    logic        m_last [256];

    always #4 clk = ~clk;

    assign fifo_free = FREE_W'(free_init - (cnt_push - base));

    wrpost_target #(.CL_DW(8), .PAGE_DW(1024), .FREE_W(FREE_W)) i_wrpost_target (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n), .ad(ad),
        .cbe_n(cbe_n), .hit(hit), .fifo_free(fifo_free), .devsel_n(devsel_n),
        .trdy_n(trdy_n), .stop_n(stop_n), .q_push(q_push), .q_is_addr(q_is_addr),
        .q_last(q_last), .q_tag(q_tag), .q_word(q_word)
    );

    // Queue model: record every pushed entry.
    always @(posedge clk) begin
        if (q_push) begin
            m_word[cnt_push % 256] <= q_word;
            m_tag[cnt_push % 256]  <= q_tag;
            m_addr[cnt_push % 256] <= q_is_addr;
            m_last[cnt_push % 256] <= q_last;
            cnt_push <= cnt_push + 1;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] pat(input int row, input int ph);
        return 32'hD000_0000 | (32'(row) << 8) | 32'(ph);
    endfunction

    typedef struct packed {
        logic [3:0]  cmd;
        logic [31:0] addr;
        logic        hit;
        logic [7:0]  free;
        logic [7:0]  ndw;
        logic [7:0]  gap;
        logic        e_claim;
        logic [7:0]  e_acc;
        logic        e_stop;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{4'h7, 32'h0000_1000, 1'b1, 8'd20, 8'd4,  8'd2, 1'b1, 8'd4, 1'b0},
        '{4'hF, 32'h0000_2008, 1'b1, 8'd20, 8'd10, 8'd0, 1'b1, 8'd6, 1'b1},
        '{4'h7, 32'h0000_3FF8, 1'b1, 8'd20, 8'd5,  8'd0, 1'b1, 8'd2, 1'b1},
        '{4'h9, 32'h0000_0100, 1'b1, 8'd4,  8'd6,  8'd0, 1'b1, 8'd3, 1'b1},
        '{4'h3, 32'h0000_1000, 1'b1, 8'd20, 8'd2,  8'd0, 1'b0, 8'd0, 1'b0},
        '{4'hB, 32'h0000_1000, 1'b1, 8'd20, 8'd2,  8'd0, 1'b0, 8'd0, 1'b0},
        '{4'h7, 32'h0000_1000, 1'b0, 8'd20, 8'd2,  8'd0, 1'b0, 8'd0, 1'b0},
        '{4'h7, 32'h0000_1000, 1'b1, 8'd1,  8'd2,  8'd0, 1'b0, 8'd0, 1'b0},
        '{4'h7, 32'h0000_5000, 1'b1, 8'd2,  8'd3,  8'd0, 1'b1, 8'd1, 1'b1},
        '{4'hF, 32'h0000_401C, 1'b1, 8'd20, 8'd1,  8'd0, 1'b1, 8'd1, 1'b1},
        '{4'h7, 32'h0000_6000, 1'b1, 8'd20, 8'd1,  8'd0, 1'b1, 8'd1, 1'b0},
        '{4'hF, 32'h0000_0040, 1'b1, 8'd20, 8'd8,  8'd3, 1'b1, 8'd8, 1'b1},
        '{4'h9, 32'h0000_7FF0, 1'b1, 8'd20, 8'd3,  8'd0, 1'b1, 8'd3, 1'b0},
        '{4'h7, 32'h0000_8FFC, 1'b1, 8'd3,  8'd4,  8'd0, 1'b1, 8'd1, 1'b1}
    };

    // One initiator burst, then checks of handshake timing and queue contents.
    task automatic run_row(input int row, input vec_t v);
        int  dev_at = -1, trdy_at = -1, sent = 0, n, bad_d = 0, bad_l = 0;
        bit  stop_seen = 0, waited = 0, xfer, fin, disc;
        @(negedge clk);
        base = cnt_push; free_init = int'(v.free);
        frame_n = 1'b0; irdy_n = 1'b1; ad = v.addr; cbe_n = v.cmd; hit = v.hit;
        @(negedge clk);
        frame_n = (v.ndw == 8'd1); irdy_n = 1'b0; ad = pat(row, 0); cbe_n = 4'h0; hit = 1'b0;
        for (int c = 1; c < 60; c++) begin
            if (!devsel_n && dev_at < 0) dev_at = c;
            if (!trdy_n && trdy_at < 0) trdy_at = c;
            xfer = !trdy_n && !irdy_n;
            if (xfer && !stop_n) stop_seen = 1;
            fin  = xfer && frame_n;
            disc = xfer && !frame_n && !stop_n;
            @(negedge clk);
            if (xfer) sent++;
            if (fin) begin
                irdy_n = 1'b1;
                check(devsel_n && trdy_n && stop_n, "R7", "pins released after last phase",
                      {devsel_n, trdy_n, stop_n}, 3'b111);
                break;
            end
            if (disc) begin
                frame_n = 1'b1;
                check(trdy_n && !stop_n && !devsel_n, "R10", "hold after disconnect",
                      {devsel_n, trdy_n, stop_n}, 3'b010);
                @(negedge clk);
                irdy_n = 1'b1;
                check(devsel_n && trdy_n && stop_n, "R10", "release after frame high",
                      {devsel_n, trdy_n, stop_n}, 3'b111);
                break;
            end
            if (dev_at < 0 && c >= 3) begin
                frame_n = 1'b1;
                @(negedge clk);
                irdy_n = 1'b1;
                break;
            end
            if (xfer) begin
                ad = pat(row, sent); cbe_n = 4'(sent);
            end
            if (xfer && v.gap != 0 && sent == int'(v.gap) && !waited) begin
                irdy_n = 1'b1; waited = 1; frame_n = 1'b0;
            end else if (xfer || irdy_n) begin
                irdy_n = 1'b0; frame_n = (sent == int'(v.ndw) - 1);
            end
        end
        @(negedge clk);
        n = cnt_push - base;
        if (v.e_claim) begin
            check(dev_at == 2, "R4", "devsel clock after address", dev_at, 2);
            check(trdy_at == 3, "R4", "trdy clock after address", trdy_at, 3);
            check(m_addr[base % 256] && m_word[base % 256] == v.addr && m_tag[base % 256] == v.cmd,
                  "R5", "address entry", m_word[base % 256], v.addr);
            check(n == 1 + int'(v.e_acc), "R6 R8 R9", "entries pushed", n, 1 + int'(v.e_acc));
            for (int i = 0; i < int'(v.e_acc) && i + 1 < n; i++) begin
                int k = (base + 1 + i) % 256;
                if (m_addr[k] || m_word[k] != pat(row, i) || m_tag[k] != ~4'(i)) bad_d++;
                if (m_last[k] != (i == int'(v.e_acc) - 1)) bad_l++;
            end
            check(bad_d == 0, "R6", "data entry contents", bad_d, 0);
            check(bad_l == 0, "R7 R8", "end flag placement", bad_l, 0);
            check(stop_seen == v.e_stop, "R8 R9", "disconnect seen", stop_seen, v.e_stop);
        end else begin
            check(dev_at == -1, "R2 R3", "no claim", dev_at, -1);
            check(n == 0, "R2 R3", "no entries", n, 0);
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(devsel_n && trdy_n && stop_n && !q_push, "R1", "pins in reset",
              {devsel_n, trdy_n, stop_n, q_push}, 4'b1110);
        rst_n = 1'b1;
        @(negedge clk);
        check(devsel_n && trdy_n && stop_n && cnt_push == 0, "R1", "pins after reset",
              {devsel_n, trdy_n, stop_n}, 3'b111);
        @(negedge clk);

        for (int r = 0; r < NV; r++) run_row(r, VECS[r]);

        // Directed: reset in the middle of a burst returns to idle at once.
        @(negedge clk);
        base = cnt_push; free_init = 20;
        frame_n = 1'b0; ad = 32'h0000_9000; cbe_n = 4'h7; hit = 1'b1;
        @(negedge clk);
        irdy_n = 1'b0; hit = 1'b0; ad = 32'h1234_5678; cbe_n = 4'h0;
        repeat (3) @(negedge clk);
        check(!trdy_n, "R6", "burst running before reset", trdy_n, 0);
        rst_n = 1'b0;
        @(negedge clk);
        check(devsel_n && trdy_n && stop_n && !q_push, "R1", "pins after mid-burst reset",
              {devsel_n, trdy_n, stop_n, q_push}, 4'b1110);
        frame_n = 1'b1; irdy_n = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(devsel_n && trdy_n && stop_n, "R1", "idle after reset release",
              {devsel_n, trdy_n, stop_n}, 3'b111);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule